// File: doc/BRIEF.md
# Configurable Timer with Prescaler

This block is a timer/counter with a byte-wide register interface. Software can make it 8 bits or 16 bits wide. It counts one of two sources: a tick that occurs on every clock cycle, or a chosen edge of an external pin. The pin is brought into the clock domain through a two-flop synchronizer and then goes through an edge detector. An 8-bit prescaler can divide the count source by any power of two from 2 to 256, or it can be bypassed.

The 16-bit value moves through a high-byte buffer. Reading the low byte captures the live high byte into the buffer. Writing the low byte loads all 16 bits at once, taking the upper half from the buffer. That same write clears the prescaler and stops counting for two cycles. When the counter wraps, a sticky interrupt flag is set. The flag is cleared only by an explicit bus write.

Top module: `cfg_timer`

## Requirements
- R1: After reset, the control register reads 0x77, which means 8-bit mode, external pin source, falling edge, prescaler in use at 1:256. The low byte, the high-byte buffer and the flag all read 0.
- R2: With the internal source selected (control bit 5 = 0) and the prescaler bypassed (control bit 3 = 1), the count rises by one on every clock.
- R3: With the prescaler in use (bit 3 = 0), one count occurs every 2^(S+1) source events, where S is control bits 2:0.
- R4: With the external source (bit 5 = 1), the count follows the synchronized pin. Bit 4 = 0 counts rising edges only, and bit 4 = 1 counts falling edges only.
- R5: In 8-bit mode (bit 6 = 1), the low byte wraps from 0xFF to 0x00 and this sets the flag.
- R6: In 16-bit mode (bit 6 = 0), a carry from the low byte goes into the high byte. Only a wrap from 0xFFFF to 0x0000 sets the flag.
- R7: A write to the low byte loads the counter. The two clock edges that follow that write produce no increment.
- R8: A write to the low byte restarts the prescaler from zero.
- R9: A read of the low byte copies the live high byte into the buffer. A write to the low byte loads {buffer, data} as one 16-bit value.
- R10: The flag stays set until a write of a value with bit 0 = 1 to address 3. Writing 0 there has no effect, and a wrap in the same cycle as a clear leaves the flag set.

Register addresses are: 0 = control (bits 6:0), 1 = low byte, 2 = high-byte buffer, 3 = flag (read in bit 0, cleared by writing bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every cycle is one internal tick |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (needed for the low-byte capture) |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| extPin | input | 1 | External count input, asynchronous |
| rdData | output | 8 | Read data for addr, combinational |
| irqFlag | output | 1 | Sticky overflow flag |

## Verification
The checks assume that bus access has one master: wrEn and rdEn are never high in the same cycle. They also assume a low-byte read that should capture the high byte is a single-cycle rdEn pulse. The two-cycle hold properties only fire when no second low-byte write falls inside the window, so back-to-back loads are left unconstrained. The stimulus changes all inputs on the falling clock edge and keeps rdEn and wrEn exclusive. It holds every external pin level for at least three cycles, so each edge passes the synchronizer exactly once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_LOW  = 2'd1,
    A_HIGH = 2'd2,
    A_FLAG = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       wide8;     // 1 = 8-bit counter
    logic       extSrc;    // 1 = external pin
    logic       fallEdge;  // 1 = falling edge
    logic       bypass;    // 1 = prescaler skipped
    logic [2:0] ratioSel;  // divide by 2^(sel+1)
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = ctrl_t'(7'h77);

  typedef struct packed {
    logic             load;
    logic             incr;
    logic             flagClr;
    logic [CNT_W-1:0] loadVal;
  } strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 2,
  parameter int PRE_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              extPin,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              irqFlag,
  output logic [BYTE_W-1:0] rdData,
  output ctrl_t             ctrl,
  output logic [BYTE_W-1:0] hbuf,
  output strobe_t           strb
);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  reg_addr_e          addrE;
  logic [SYNC_STAGES:0] syncQ;
  logic [HOLD_W-1:0]  holdQ;
  logic [PRE_W-1:0]   preQ;
  logic [PRE_W-1:0]   preMask;
  logic lowWr, lowRd, running, pinNow, pinOld, edgeHit, srcEvt, preTick, cntTick;

  assign addrE   = reg_addr_e'(addr);
  assign lowWr   = wrEn && (addrE == A_LOW);
  assign lowRd   = rdEn && !wrEn && (addrE == A_LOW);
  assign running = (holdQ == '0) && !lowWr;

  // control register and high-byte buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrl <= CTRL_RESET;
      hbuf <= '0;
    end else begin
      if (wrEn && addrE == A_CTRL) ctrl <= ctrl_t'(wrData[6:0]);
      if (wrEn && addrE == A_HIGH) hbuf <= wrData;
      else if (lowRd)              hbuf <= cntVal[CNT_W-1:BYTE_W];
    end
  end

  // synchronizer chain plus one history flop for the edge detector
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], extPin};
  end

  assign pinNow  = syncQ[SYNC_STAGES-1];
  assign pinOld  = syncQ[SYNC_STAGES];
  assign edgeHit = ctrl.fallEdge ? (pinOld && !pinNow) : (pinNow && !pinOld);
  assign srcEvt  = ctrl.extSrc ? edgeHit : 1'b1;

  // post-write hold window
  always_ff @(posedge clk) begin
    if (!rstN)              holdQ <= '0;
    else if (lowWr)         holdQ <= HOLD_W'(HOLD_CYCLES);
    else if (holdQ != '0)   holdQ <= holdQ - 1'b1;
  end

  // prescaler: free-running count, tap selected by mask
  always_ff @(posedge clk) begin
    if (!rstN || lowWr)          preQ <= '0;
    else if (srcEvt && running)  preQ <= preQ + 1'b1;
  end

  assign preMask = PRE_W'((32'd1 << (32'(ctrl.ratioSel) + 32'd1)) - 32'd1);
  assign preTick = srcEvt && ((preQ & preMask) == preMask);
  assign cntTick = ctrl.bypass ? srcEvt : preTick;

  assign strb.load    = lowWr;
  assign strb.incr    = cntTick && running;
  assign strb.flagClr = wrEn && (addrE == A_FLAG) && wrData[0];
  assign strb.loadVal = {hbuf, wrData};

  always_comb begin
    unique case (addrE)
      A_CTRL:  rdData = {1'b0, ctrl};
      A_LOW:   rdData = cntVal[BYTE_W-1:0];
      A_HIGH:  rdData = hbuf;
      default: rdData = {{(BYTE_W-1){1'b0}}, irqFlag};
    endcase
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             mode8,
  output logic [CNT_W-1:0] cntVal,
  output logic             irqFlag
);
  logic wrap;

  assign wrap = strb.incr && (mode8 ? (&cntVal[BYTE_W-1:0]) : (&cntVal));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal  <= '0;
      irqFlag <= 1'b0;
    end else begin
      if (strb.load)
        cntVal <= strb.loadVal;
      else if (strb.incr) begin
        if (mode8) cntVal[BYTE_W-1:0] <= cntVal[BYTE_W-1:0] + 1'b1;
        else       cntVal <= cntVal + 1'b1;
      end
      if (wrap)              irqFlag <= 1'b1;
      else if (strb.flagClr) irqFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 2,
  parameter int PRE_W       = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  input  logic       extPin,
  output logic [7:0] rdData,
  output logic       irqFlag
);
  ctrl_t            ctrl;
  strobe_t          strb;
  logic [CNT_W-1:0] cntVal;
  logic [BYTE_W-1:0] hbuf;

  tmr_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .HOLD_CYCLES(HOLD_CYCLES),
    .PRE_W(PRE_W)
  ) i_tmrCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .extPin(extPin), .cntVal(cntVal), .irqFlag(irqFlag),
    .rdData(rdData), .ctrl(ctrl), .hbuf(hbuf), .strb(strb)
  );

  tmr_datapath i_tmrDatapath (
    .clk(clk), .rstN(rstN), .strb(strb), .mode8(ctrl.wide8),
    .cntVal(cntVal), .irqFlag(irqFlag)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        rdEn,
  input logic [1:0]  addr,
  input logic [15:0] cntVal,
  input logic [7:0]  hbuf,
  input logic        irqFlag,
  input logic        loadPulse,
  input logic        clrWrite,
  input logic        mode8
);
  AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse ##1 !loadPulse ##1 !loadPulse |-> $stable(cntVal)); // R7
  AST_HOLD_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse ##1 !loadPulse ##1 !loadPulse |=> $stable(cntVal)); // R7
  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> cntVal[7:0] == 8'h00); // R5
  AST_WRAP_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) && !$past(mode8) |-> cntVal == 16'h0000); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !clrWrite |=> irqFlag); // R10
  AST_FLAG_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> $past(clrWrite)); // R10
  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !wrEn && addr == 2'd1 |=> hbuf == $past(cntVal[15:8])); // R9
endmodule

bind cfg_timer tmr_checker i_tmrChecker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .cntVal(cntVal), .hbuf(hbuf), .irqFlag(irqFlag),
  .loadPulse(strb.load), .clrWrite(strb.flagClr), .mode8(ctrl.wide8)
);

// File: tb/test_cfg_timer.sv
module test_cfg_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic       extPin = 1'b0;
  logic [7:0] rdData;
  logic       irqFlag;
  int checks = 0;
  int fails = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  cfg_timer i_cfg_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .extPin(extPin), .rdData(rdData), .irqFlag(irqFlag)
  );

  typedef struct packed {
    logic [7:0]  ctrlVal;
    logic [15:0] waitN;
    logic [7:0]  expCnt;
  } vec_t;

  // count = floor((N-2)/ratio) edges after a low write (two held edges)
  localparam vec_t VECS [11] = '{
    '{8'h40, 16'd40,  8'd19},
    '{8'h41, 16'd42,  8'd10},
    '{8'h42, 16'd50,  8'd6},
    '{8'h43, 16'd100, 8'd6},
    '{8'h44, 16'd200, 8'd6},
    '{8'h45, 16'd300, 8'd4},
    '{8'h46, 16'd400, 8'd3},
    '{8'h47, 16'd600, 8'd2},
    '{8'h48, 16'd30,  8'd28},
    '{8'h48, 16'd2,   8'd0},
    '{8'h48, 16'd3,   8'd1}
  };

  task automatic checkEq(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    addr = a; rdEn = (a == 2'd1);
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulsePin();
    extPin = 1'b1; waitEdges(3);
    extPin = 1'b0; waitEdges(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    waitEdges(3);
    rstN = 1'b1;
    // R1 reset state
    readReg(2'd0, got); checkEq("R1 ctrl", got, 8'h77);
    readReg(2'd1, got); checkEq("R1 low", got, 8'h00);
    readReg(2'd2, got); checkEq("R1 hbuf", got, 8'h00);
    readReg(2'd3, got); checkEq("R1 flag", got, 8'h00);

    // R2 / R3 / R7 table walk
    for (int i = 0; i < 11; i++) begin
      busWrite(2'd0, VECS[i].ctrlVal);
      busWrite(2'd1, 8'h00);
      waitEdges(int'(VECS[i].waitN));
      readReg(2'd1, got);
      if (VECS[i].waitN <= 16'd3)     checkEq("R7 hold", got, VECS[i].expCnt);
      else if (VECS[i].ctrlVal[3])    checkEq("R2 bypass", got, VECS[i].expCnt);
      else                            checkEq("R3 ratio", got, VECS[i].expCnt);
    end

    // R8 low write restarts the prescaler (1:16)
    busWrite(2'd0, 8'h43);
    busWrite(2'd1, 8'h00);
    waitEdges(20);
    readReg(2'd1, got); checkEq("R8 first", got, 8'h01);
    busWrite(2'd1, 8'h00);
    waitEdges(17);
    readReg(2'd1, got); checkEq("R8 cleared", got, 8'h00);

    // R4 rising edges
    busWrite(2'd0, 8'h68);
    busWrite(2'd1, 8'h00);
    waitEdges(3);
    for (int p = 0; p < 5; p++) pulsePin();
    waitEdges(4);
    readReg(2'd1, got); checkEq("R4 rising", got, 8'h05);
    // R4 falling edges only
    busWrite(2'd0, 8'h78);
    busWrite(2'd1, 8'h00);
    waitEdges(3);
    extPin = 1'b1; waitEdges(5);
    readReg(2'd1, got); checkEq("R4 rise ignored", got, 8'h00);
    extPin = 1'b0; waitEdges(5);
    readReg(2'd1, got); checkEq("R4 falling", got, 8'h01);

    // R5 8-bit wrap
    busWrite(2'd0, 8'h48);
    busWrite(2'd1, 8'hFD);
    waitEdges(4);
    readReg(2'd3, got); checkEq("R5 before wrap", got, 8'h00);
    readReg(2'd3, got); checkEq("R5 wrap flag", got, 8'h01);
    readReg(2'd1, got); checkEq("R5 low after", got, 8'h01);
    // R10 clear behaviour
    busWrite(2'd3, 8'h00);
    readReg(2'd3, got); checkEq("R10 zero write", got, 8'h01);
    busWrite(2'd3, 8'h01);
    readReg(2'd3, got); checkEq("R10 clear", got, 8'h00);
    busWrite(2'd1, 8'hFD);
    waitEdges(4);
    busWrite(2'd3, 8'h01);
    readReg(2'd3, got); checkEq("R10 wrap wins", got, 8'h01);
    busWrite(2'd3, 8'h01);
    readReg(2'd3, got); checkEq("R10 clear again", got, 8'h00);

    // R6 / R9 16-bit carry, commit and capture
    busWrite(2'd0, 8'h08);
    busWrite(2'd2, 8'h12);
    busWrite(2'd1, 8'hFE);
    waitEdges(4);
    readReg(2'd1, got); checkEq("R6 carry low", got, 8'h00);
    readReg(2'd2, got); checkEq("R9 capture", got, 8'h13);
    readReg(2'd3, got); checkEq("R6 no flag", got, 8'h00);
    busWrite(2'd2, 8'hFF);
    busWrite(2'd1, 8'hFD);
    waitEdges(5);
    readReg(2'd3, got); checkEq("R6 full wrap", got, 8'h01);
    readReg(2'd1, got); checkEq("R6 low after", got, 8'h01);
    readReg(2'd2, got); checkEq("R9 capture zero", got, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule